// File: doc/BRIEF.md
# Priority-Level Banked Working Register File

This block is the working register file of a 32-bit CPU core: sixteen registers, two combinational read ports and one write port. Registers 0 to 7 exist once for each of eight priority levels. A 3-bit level input picks which copy of that lower half is visible. Level 0 shows the base copy, and levels 1 to 7 show their own alternate copies. Registers 8 to 15 exist once and are the same at every level.

An interrupt handler running at a raised level therefore gets a fresh set of lower registers without saving or restoring anything. The upper registers still let it pass values to and from other levels.

Writes carry a size code, so byte, word and long-word results update only their own low lanes. A write in the same cycle as a read of the same register is forwarded to the read port. Reset clears every copy at every level.

Top module: `banked_regfile`

## Requirements
- R1: Both read ports return, in the same cycle and without a clock edge, the 32-bit content of the register named by their 4-bit address.
- R2: For registers 0 to 7, level value 0 selects the base copy and level values 1 to 7 select alternate copies 1 to 7. Each copy is independent of the others.
- R3: Registers 8 to 15 have one copy, read and written identically at every level.
- R4: The size code selects the lanes a write updates. Code 0 updates bits 7:0, code 1 updates bits 15:0, and codes 2 and 3 update all 32 bits. Bits outside the selected lanes keep their value.
- R5: When the write enable is low, no register in any copy changes.
- R6: When a read port's address equals the write address while the write enable is high, that port returns the value the register will hold after the edge, including the kept lanes.
- R7: The asynchronous active-low reset clears every register of every copy to zero.
- R8: A write to registers 0 to 7 lands in the copy of the level present in the cycle of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lvl | input | 3 | Current priority level, picks the copy of registers 0-7 |
| we | input | 1 | Write enable |
| wsize | input | 2 | Write size: 0 byte, 1 word, 2 or 3 long word |
| waddr | input | 4 | Write register number |
| wdata | input | 32 | Write data, low-aligned |
| ra_addr | input | 4 | Read port A register number |
| ra_data | output | 32 | Read port A data |
| rb_addr | input | 4 | Read port B register number |
| rb_data | output | 32 | Read port B data |

## Verification
The assertions assume that the level, the write controls and the write data are settled before each rising edge and stay defined once reset is released. Without that, the copy a write targets or the lanes it keeps would be unknown. The bench changes every input just after the falling edge and only while reset is stable, so each input is set half a period before the edge that uses it. The bench moves the level between nearly every pair of cycles, both with and without writes, so that bank crossings, forwarding and partial writes are exercised together.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW     = 32,
  parameter int NREG   = 16,
  parameter int NLEVEL = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(NLEVEL)-1:0] lvl,
  input  logic                      we,
  input  logic [1:0]                wsize,
  input  logic [$clog2(NREG)-1:0]   waddr,
  input  logic [DW-1:0]             wdata,
  input  logic [$clog2(NREG)-1:0]   ra_addr,
  output logic [DW-1:0]             ra_data,
  input  logic [$clog2(NREG)-1:0]   rb_addr,
  output logic [DW-1:0]             rb_data
);
  localparam int AW   = $clog2(NREG);
  localparam int LW   = $clog2(NLEVEL);
  localparam int NHALF = NREG / 2;
  localparam int IW   = $clog2(NHALF);

  logic [DW-1:0] bank_q   [NLEVEL][NHALF];
  logic [DW-1:0] shared_q [NHALF];

  wire [IW-1:0] widx = waddr[IW-1:0];
  wire          wshr = waddr[AW-1];

  wire [DW-1:0] lane_mask =
      (wsize == 2'd0) ? {{(DW-8){1'b0}}, 8'hFF} :
      (wsize == 2'd1) ? {{(DW-16){1'b0}}, 16'hFFFF} : {DW{1'b1}};

  wire [DW-1:0] w_old  = wshr ? shared_q[widx] : bank_q[lvl][widx];
  wire [DW-1:0] merged = (w_old & ~lane_mask) | (wdata & lane_mask);

  wire [DW-1:0] ra_raw = ra_addr[AW-1] ? shared_q[ra_addr[IW-1:0]]
                                       : bank_q[lvl][ra_addr[IW-1:0]];
  wire [DW-1:0] rb_raw = rb_addr[AW-1] ? shared_q[rb_addr[IW-1:0]]
                                       : bank_q[lvl][rb_addr[IW-1:0]];

  assign ra_data = (we && ra_addr == waddr) ? merged : ra_raw;
  assign rb_data = (we && rb_addr == waddr) ? merged : rb_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NLEVEL; l++)
        for (int i = 0; i < NHALF; i++)
          bank_q[l][i] <= '0;
      for (int i = 0; i < NHALF; i++)
        shared_q[i] <= '0;
    end else if (we) begin
      if (wshr) shared_q[widx] <= merged;
      else      bank_q[lvl][widx] <= merged;
    end
  end

  wire [LW-1:0] nb_lvl = lvl + LW'(1);

  AST_LONG_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    we && wshr && wsize[1] |=> shared_q[$past(widx)] == $past(wdata)); // R3

  AST_BYTE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    we && wsize == 2'd0 |=> ra_raw[DW-1:8] == $past(w_old[DW-1:8]) || $past(ra_addr) != $past(waddr) || $past(lvl) != lvl || $past(ra_addr) != ra_addr); // R4

  AST_OTHER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    we && !wshr |=> bank_q[$past(nb_lvl)][$past(widx)] == $past(bank_q[nb_lvl][widx])); // R8

  AST_FWD_A: assert property (@(posedge clk) disable iff (!rst_n)
    we && wsize[1] && ra_addr == waddr |-> ra_data == wdata); // R6

  AST_FWD_B: assert property (@(posedge clk) disable iff (!rst_n)
    we && wsize[1] && rb_addr == waddr |-> rb_data == wdata); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we && ra_addr[AW-1] |=> $past(ra_addr) != ra_addr || ra_data == $past(ra_data) || we); // R5
endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  localparam int PERIOD = 10;
  localparam int NV = 15;
  // {lvl[77:75], we[74], wsize[73:72], waddr[71:68], wdata[67:36], raddr[35:32], exp[31:0]}
  localparam logic [77:0] VEC [NV] = '{
    {3'd0,1'b1,2'd2,4'd0, 32'h11111111,4'd0, 32'h11111111}, // R6
    {3'd0,1'b0,2'd2,4'd0, 32'h0,       4'd0, 32'h11111111}, // R1
    {3'd3,1'b0,2'd2,4'd0, 32'h0,       4'd0, 32'h00000000}, // R2
    {3'd3,1'b1,2'd2,4'd0, 32'hA5A5A5A5,4'd0, 32'hA5A5A5A5}, // R8
    {3'd0,1'b0,2'd0,4'd0, 32'h0,       4'd0, 32'h11111111}, // R2
    {3'd3,1'b1,2'd0,4'd0, 32'h000000CC,4'd0, 32'hA5A5A5CC}, // R4 R6
    {3'd3,1'b0,2'd0,4'd0, 32'h0,       4'd0, 32'hA5A5A5CC}, // R4
    {3'd3,1'b1,2'd1,4'd0, 32'h1234BEEF,4'd0, 32'hA5A5BEEF}, // R4
    {3'd5,1'b1,2'd2,4'd9, 32'hCAFEF00D,4'd9, 32'hCAFEF00D}, // R3
    {3'd2,1'b0,2'd2,4'd0, 32'h0,       4'd9, 32'hCAFEF00D}, // R3
    {3'd7,1'b1,2'd2,4'd7, 32'h77777777,4'd7, 32'h77777777}, // R8
    {3'd0,1'b0,2'd2,4'd0, 32'h0,       4'd7, 32'h00000000}, // R2
    {3'd7,1'b1,2'd1,4'd15,32'hFFFFABCD,4'd15,32'h0000ABCD}, // R4
    {3'd1,1'b0,2'd2,4'd0, 32'hFFFFFFFF,4'd0, 32'h00000000}, // R5
    {3'd1,1'b0,2'd2,4'd0, 32'h0,       4'd0, 32'h00000000}  // R5
  };

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [2:0] lvl = '0;
  logic [1:0] wsize = '0;
  logic [3:0] waddr = '0, ra_addr = '0, rb_addr = '0;
  logic [31:0] wdata = '0, ra_data, rb_data;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  banked_regfile u0 (.clk, .rst_n, .lvl, .we, .wsize, .waddr, .wdata,
                     .ra_addr, .ra_data, .rb_addr, .rb_data);

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic setin(input logic [2:0] l, input logic w, input logic [1:0] s,
                       input logic [3:0] wa, input logic [31:0] wd,
                       input logic [3:0] a, input logic [3:0] b);
    lvl = l; we = w; wsize = s; waddr = wa; wdata = wd; ra_addr = a; rb_addr = b;
    #1;
  endtask

  task automatic all_zero(input string req);
    for (int l = 0; l < 8; l += 3)
      for (int r = 0; r < 16; r++) begin
        setin(3'(l), 1'b0, 2'd2, 4'd0, 32'h0, 4'(r), 4'(15 - r));
        check(req, ra_data, 32'h0);
        check(req, rb_data, 32'h0);
      end
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    all_zero("R7 reset state");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NV; k++) begin
      setin(VEC[k][77:75], VEC[k][74], VEC[k][73:72], VEC[k][71:68],
            VEC[k][67:36], VEC[k][35:32], 4'd8);
      check($sformatf("vector %0d", k), ra_data, VEC[k][31:0]);
      @(negedge clk);
    end
    // R6 forwarding on port B, R2 other level unaffected
    setin(3'd2, 1'b1, 2'd2, 4'd3, 32'hDEADBEEF, 4'd3, 4'd3);
    check("R6 port B fwd", rb_data, 32'hDEADBEEF);
    @(negedge clk);
    setin(3'd4, 1'b0, 2'd2, 4'd0, 32'h0, 4'd3, 4'd8);
    check("R2 level 4 copy", ra_data, 32'h0);
    @(negedge clk);
    setin(3'd2, 1'b0, 2'd2, 4'd0, 32'h0, 4'd0, 4'd3);
    check("R1 port B read", rb_data, 32'hDEADBEEF);
    check("R2 level 2 reg0", ra_data, 32'h0);
    @(negedge clk);
    // R4 size code 3 is long word
    setin(3'd2, 1'b1, 2'd3, 4'd3, 32'h01020304, 4'd0, 4'd0);
    @(negedge clk);
    setin(3'd2, 1'b0, 2'd0, 4'd0, 32'h0, 4'd0, 4'd3);
    check("R4 size 3 long", rb_data, 32'h01020304);
    // R3 word write to shared register from another level
    setin(3'd6, 1'b1, 2'd1, 4'd12, 32'hFFFF5555, 4'd0, 4'd0);
    @(negedge clk);
    setin(3'd1, 1'b0, 2'd0, 4'd0, 32'h0, 4'd12, 4'd9);
    check("R3 shared word", ra_data, 32'h00005555);
    check("R3 shared held", rb_data, 32'hCAFEF00D);
    // R5 disabled write of a byte to register 12
    setin(3'd1, 1'b0, 2'd0, 4'd12, 32'h000000AA, 4'd12, 4'd0);
    @(negedge clk);
    setin(3'd1, 1'b0, 2'd0, 4'd0, 32'h0, 4'd12, 4'd0);
    check("R5 no write", ra_data, 32'h00005555);
    // R7 reset mid-run
    rst_n = 1'b0;
    #1;
    all_zero("R7 reset clears");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule